// File: doc/BRIEF.md
# Wireless Receiver Control Register Logic

This block is the digital control core of a wireless-power receiver and battery charger. A simple register bus reaches eight read/write configuration registers and one read-only fault register. Six status lines from the analog side enter through two-flop synchronizers: incoming AC power, USB supply present, over-temperature, rectified-rail over-voltage, battery-rail over-voltage and current limit active. The synchronized status and the register contents together drive the control outputs. These are the rectifier switching mode, the load-switch mode, the precharge source, the thermistor driver, the modulation switches, the over-voltage clamp FET, a one-hot analog-mux select, the choice of LDO supply and the low-power request.

Thermal shutdown and a USB supply can override the register settings. Over-temperature always wins. USB blocking depends on a static trim input. After reset the rectifier is held in diode-only operation until incoming power is seen or a charge path is enabled. A low-power request clears itself when incoming power arrives. The reset input is asynchronous, active low, and must already be released in step with `clk`.

Top module: `wpr_ctrl_core`

## Requirements
- R1: Configuration registers at addresses 0x0 to 0x7 are read/write and reset to 0x00. A read strobe loads `bus_rdata` at the clock edge, and `bus_rdata` then holds until the next read strobe.
- R2: Address 0x8 reads the live synchronized fault levels: bit0 current limit, bit1 USB present, bit2 over-temperature, bit3 rectified-rail over-voltage, bit4 battery-rail over-voltage, bits 7:5 zero. Each status input reaches the logic two clock edges after it changes.
- R3: Writes to 0x8 and to addresses 0x9 to 0xF change nothing. Reads of 0x9 to 0xF return 0x00.
- R4: Register 0x0 bit4 (active low) forces diode-only operation and takes priority over bit5. Bit5 (active low) forces low-side-only switching. With both bits high, full switching is allowed. `rect_mode` encodes 0 diode-only, 1 low-side-only, 2 full.
- R5: After reset, `rect_mode` stays 0 until synchronized incoming power, reg0 bit0 or reg0 bit1 has been seen high at a clock edge. From the following cycle on, the R4 decode applies.
- R6: The load switch uses reg0 bit2 (regulator) and bit0 (switch). With bit2 set, `sw_mode` is 2 (linear) whatever bit0 is. With bit2 clear and bit0 set, `sw_mode` is 1 (hard switch). With both clear, `sw_mode` is 0 (off).
- R7: While synchronized over-temperature is high, `sw_mode` is 0, `pre_en` is 0 and `rect_mode` is 0. `mod_en` (reg0 bit3) and `ovp_fet` are unaffected.
- R8: While synchronized USB is present and `trim_usb_keep` is low, `sw_mode` is 0, `pre_en` is 0 and `ldo_from_usb` is 1. With `trim_usb_keep` high, USB has none of these effects.
- R9: Register 0x3 bits 1:0 select the thermistor driver: 0 off, 1 on, 2 on exactly when reg0 bit0 or bit1 is set, 3 off.
- R10: Register 0x2 bits 2:0 give the mux code. Code 0 drives `amux_oh` all zero, and code k in 1..7 drives bit k-1 alone.
- R11: `ovp_fet` is high when the synchronized rectified-rail over-voltage is high or reg1 bit7 is set.
- R12: `low_power` follows reg1 bit6 while no incoming power is synchronized. Synchronized incoming power forces `low_power` low at once and clears reg1 bit6 at the next edge, winning over a write in that same cycle.
- R13: `pre_en` follows reg0 bit1 subject to R7 and R8. `pre_level` shows reg1 bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| st_vac | input | 1 | Incoming AC power detected (asynchronous) |
| st_usb | input | 1 | USB supply present (asynchronous) |
| st_otemp | input | 1 | Over-temperature (asynchronous) |
| st_pdc_ovp | input | 1 | Rectified-rail over-voltage (asynchronous) |
| st_pack_ovp | input | 1 | Battery-rail over-voltage (asynchronous) |
| st_ilim | input | 1 | Current limit active (asynchronous) |
| trim_usb_keep | input | 1 | Static trim; high keeps charging on while USB is present |
| rect_mode | output | 2 | Rectifier mode: 0 diode-only, 1 low-side-only, 2 full |
| sw_mode | output | 2 | Load switch: 0 off, 1 hard switch, 2 linear regulator |
| pre_en | output | 1 | Precharge current source enable |
| pre_level | output | 3 | Precharge level code |
| therm_drv | output | 1 | Thermistor driver enable |
| mod_en | output | 1 | Modulation switches enable |
| ovp_fet | output | 1 | Over-voltage clamp FET on |
| amux_oh | output | 7 | One-hot analog-mux select |
| ldo_from_usb | output | 1 | LDO draws from USB instead of battery |
| low_power | output | 1 | Low-power mode request |

## Verification
A register write shows on the control outputs right after the edge that takes it, while a read appears on `bus_rdata` one edge after the strobe. A status input shows on the outputs and in the fault byte two edges after it changes, and the diode-only hold after reset lifts one edge after its arming condition. The bench models these delays directly: a two-entry queue for the synchronizers, an arming flag, a register image and a read-data register, all updated at each rising edge. Every output is then compared one nanosecond after each falling edge, so each expected value is taken in the exact cycle it is due and away from the edge where it changes.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int STAT_W   = 6;
  localparam int AMUX_W   = 3;
  localparam int NUM_AMUX = (1 << AMUX_W) - 1;
  localparam int THERM_W  = 2;
  localparam int PRE_W    = 3;

  // register indices
  localparam int CTL_IDX = 0;
  localparam int SUP_IDX = 1;
  localparam int AMX_IDX = 2;
  localparam int THM_IDX = 3;

  // control register bits
  localparam int B_SW   = 0;
  localparam int B_PRE  = 1;
  localparam int B_TOP  = 2;
  localparam int B_MOD  = 3;
  localparam int B_SYNC = 4;
  localparam int B_HS   = 5;
  // supply register bits
  localparam int B_LP   = 6;
  localparam int B_OVPF = 7;

  typedef enum logic [1:0] {RECT_ASYNC = 2'd0, RECT_HALF = 2'd1, RECT_FULL = 2'd2} rect_mode_e;
  typedef enum logic [1:0] {LSW_OFF = 2'd0, LSW_SWITCH = 2'd1, LSW_LINEAR = 2'd2} lsw_mode_e;
  typedef enum logic [THERM_W-1:0] {TH_OFF = 2'd0, TH_ON = 2'd1, TH_AUTO = 2'd2, TH_RSVD = 2'd3} therm_code_e;

  typedef struct packed {
    logic vac;
    logic pack_ovp;
    logic pdc_ovp;
    logic otemp;
    logic usb;
    logic ilim;
  } stat_t;

  typedef struct packed {
    logic sw_on;
    logic pre_on;
    logic top_on;
    logic mod_on;
    logic sync_ok;
    logic hs_ok;
    logic lp_req;
    logic ovp_force;
    logic [PRE_W-1:0]   pre_level;
    logic [AMUX_W-1:0]  amux_code;
    logic [THERM_W-1:0] therm_code;
  } cfg_t;
endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    if (g == 0) begin : g_first
      assign d = din;
    end else begin : g_next
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/wpr_regs.sv
module wpr_regs
  import wpr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [DATA_W-1:0]         fault_byte,
  input  logic                      wake,
  output logic [DATA_W-1:0]         rdata,
  output cfg_t                      cfg,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
  localparam int                IDX_W      = $clog2(NUM_CFG);
  localparam logic [ADDR_W-1:0] FAULT_ADDR = ADDR_W'(NUM_CFG);

  logic [NUM_CFG-1:0][DATA_W-1:0] reg_q, reg_d;
  logic [DATA_W-1:0]              rdata_q, rdata_d;
  logic [IDX_W-1:0]               idx;
  logic                           hit_cfg, hit_fault, reg_en;

  assign idx       = addr[IDX_W-1:0];
  assign hit_cfg   = addr < FAULT_ADDR;
  assign hit_fault = addr == FAULT_ADDR;
  assign reg_en    = (wr && hit_cfg) || wake;

  always_comb begin
    reg_d = reg_q;
    if (wr && hit_cfg) reg_d[idx] = wdata;
    if (wake)          reg_d[SUP_IDX][B_LP] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  always_comb begin
    if (hit_cfg)        rdata_d = reg_q[idx];
    else if (hit_fault) rdata_d = fault_byte;
    else                rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign cfg_flat = reg_q;

  assign cfg.sw_on      = reg_q[CTL_IDX][B_SW];
  assign cfg.pre_on     = reg_q[CTL_IDX][B_PRE];
  assign cfg.top_on     = reg_q[CTL_IDX][B_TOP];
  assign cfg.mod_on     = reg_q[CTL_IDX][B_MOD];
  assign cfg.sync_ok    = reg_q[CTL_IDX][B_SYNC];
  assign cfg.hs_ok      = reg_q[CTL_IDX][B_HS];
  assign cfg.lp_req     = reg_q[SUP_IDX][B_LP];
  assign cfg.ovp_force  = reg_q[SUP_IDX][B_OVPF];
  assign cfg.pre_level  = reg_q[SUP_IDX][PRE_W-1:0];
  assign cfg.amux_code  = reg_q[AMX_IDX][AMUX_W-1:0];
  assign cfg.therm_code = reg_q[THM_IDX][THERM_W-1:0];
endmodule

// File: rtl/wpr_mode.sv
module wpr_mode
  import wpr_pkg::*;
#(
  parameter int N_AMUX = NUM_AMUX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  stat_t             stat,
  input  logic              trim_usb_keep,
  output rect_mode_e        rect_mode,
  output lsw_mode_e         sw_mode,
  output logic              pre_en,
  output logic              therm_drv,
  output logic              mod_en,
  output logic              ovp_fet,
  output logic [N_AMUX-1:0] amux_oh,
  output logic              ldo_from_usb,
  output logic              low_power
);
  logic armed_q, armed_d, armed_en;
  logic usb_block, charge_req, path_block;

  assign charge_req = cfg.sw_on | cfg.pre_on;
  assign armed_d    = armed_q | stat.vac | charge_req;
  assign armed_en   = ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign usb_block  = stat.usb & ~trim_usb_keep;
  assign path_block = stat.otemp | usb_block;

  always_comb begin
    if (stat.otemp || !armed_q || !cfg.sync_ok) rect_mode = RECT_ASYNC;
    else if (!cfg.hs_ok)                         rect_mode = RECT_HALF;
    else                                         rect_mode = RECT_FULL;
  end

  always_comb begin
    if (path_block)      sw_mode = LSW_OFF;
    else if (cfg.top_on) sw_mode = LSW_LINEAR;
    else if (cfg.sw_on)  sw_mode = LSW_SWITCH;
    else                 sw_mode = LSW_OFF;
  end

  always_comb begin
    case (therm_code_e'(cfg.therm_code))
      TH_ON:   therm_drv = 1'b1;
      TH_AUTO: therm_drv = charge_req;
      default: therm_drv = 1'b0;
    endcase
  end

  for (genvar g = 0; g < N_AMUX; g++) begin : g_amux
    assign amux_oh[g] = (cfg.amux_code == AMUX_W'(g + 1));
  end

  assign pre_en       = cfg.pre_on & ~path_block;
  assign mod_en       = cfg.mod_on;
  assign ovp_fet      = stat.pdc_ovp | cfg.ovp_force;
  assign ldo_from_usb = usb_block;
  assign low_power    = cfg.lp_req & ~stat.vac;
endmodule

// File: rtl/wpr_ctrl_core.sv
module wpr_ctrl_core
  import wpr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 8,
  parameter int SYNC_N  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                st_vac,
  input  logic                st_usb,
  input  logic                st_otemp,
  input  logic                st_pdc_ovp,
  input  logic                st_pack_ovp,
  input  logic                st_ilim,
  input  logic                trim_usb_keep,
  output logic [1:0]          rect_mode,
  output logic [1:0]          sw_mode,
  output logic                pre_en,
  output logic [PRE_W-1:0]    pre_level,
  output logic                therm_drv,
  output logic                mod_en,
  output logic                ovp_fet,
  output logic [NUM_AMUX-1:0] amux_oh,
  output logic                ldo_from_usb,
  output logic                low_power
);
  stat_t                     stat_s;
  logic [STAT_W-1:0]         stat_raw, stat_sync;
  logic [DATA_W-1:0]         fault_byte;
  cfg_t                      cfg;
  logic [NUM_CFG*DATA_W-1:0] cfg_flat;
  rect_mode_e                rect_e;
  lsw_mode_e                 lsw_e;

  assign stat_raw = {st_vac, st_pack_ovp, st_pdc_ovp, st_otemp, st_usb, st_ilim};

  wpr_sync #(.WIDTH(STAT_W), .STAGES(SYNC_N)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (stat_raw),
    .dout (stat_sync)
  );

  assign stat_s     = stat_t'(stat_sync);
  assign fault_byte = DATA_W'({stat_s.pack_ovp, stat_s.pdc_ovp, stat_s.otemp, stat_s.usb, stat_s.ilim});

  wpr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .fault_byte(fault_byte),
    .wake      (stat_s.vac),
    .rdata     (bus_rdata),
    .cfg       (cfg),
    .cfg_flat  (cfg_flat)
  );

  wpr_mode #(.N_AMUX(NUM_AMUX)) i_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (cfg),
    .stat         (stat_s),
    .trim_usb_keep(trim_usb_keep),
    .rect_mode    (rect_e),
    .sw_mode      (lsw_e),
    .pre_en       (pre_en),
    .therm_drv    (therm_drv),
    .mod_en       (mod_en),
    .ovp_fet      (ovp_fet),
    .amux_oh      (amux_oh),
    .ldo_from_usb (ldo_from_usb),
    .low_power    (low_power)
  );

  assign rect_mode = rect_e;
  assign sw_mode   = lsw_e;
  assign pre_level = cfg.pre_level;
endmodule

// File: rtl/wpr_ctrl_chk.sv
module wpr_ctrl_chk
  import wpr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input stat_t                     stat_s,
  input logic [NUM_CFG*DATA_W-1:0] cfg_flat,
  input logic                      trim_usb_keep,
  input logic [1:0]                rect_mode,
  input logic [1:0]                sw_mode,
  input logic                      pre_en,
  input logic                      ovp_fet,
  input logic [NUM_AMUX-1:0]       amux_oh,
  input logic                      ldo_from_usb,
  input logic                      low_power
);
  localparam logic [ADDR_W-1:0] FAULT_ADDR = ADDR_W'(NUM_CFG);

  // R3: a write at or above the fault address leaves the register image alone
  a_r3_no_write_above_map: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= FAULT_ADDR && !stat_s.vac) |=> $stable(cfg_flat));

  // R4: only the three defined rectifier codes appear
  a_r4_rect_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rect_mode != 2'd3);

  // R6: only the three defined load-switch codes appear
  a_r6_sw_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode != 2'd3);

  // R7: over-temperature shuts every high-current path
  a_r7_tsd_paths_off: assert property (@(posedge clk) disable iff (!rst_n)
    stat_s.otemp |-> (sw_mode == 2'd0 && !pre_en && rect_mode == 2'd0));

  // R8: USB without keep-trim blocks charging and moves the LDO supply
  a_r8_usb_blocks_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_s.usb && !trim_usb_keep) |-> (sw_mode == 2'd0 && !pre_en && ldo_from_usb));

  // R10: at most one mux select is active
  a_r10_amux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amux_oh));

  // R11: rectified-rail over-voltage always turns the clamp on
  a_r11_ovp_clamp_on: assert property (@(posedge clk) disable iff (!rst_n)
    stat_s.pdc_ovp |-> ovp_fet);

  // R12: incoming power ends low-power mode and keeps it ended
  a_r12_wake_clears_lp: assert property (@(posedge clk) disable iff (!rst_n)
    stat_s.vac |=> !low_power);
endmodule

bind wpr_ctrl_core wpr_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .stat_s       (stat_s),
  .cfg_flat     (cfg_flat),
  .trim_usb_keep(trim_usb_keep),
  .rect_mode    (rect_mode),
  .sw_mode      (sw_mode),
  .pre_en       (pre_en),
  .ovp_fet      (ovp_fet),
  .amux_oh      (amux_oh),
  .ldo_from_usb (ldo_from_usb),
  .low_power    (low_power)
);

// File: tb/test_wpr_ctrl_core.sv
module test_wpr_ctrl_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_rdata;
  logic       st_vac, st_usb, st_otemp, st_pdc_ovp, st_pack_ovp, st_ilim;
  logic       trim_usb_keep;
  logic [1:0] rect_mode, sw_mode;
  logic       pre_en, therm_drv, mod_en, ovp_fet, ldo_from_usb, low_power;
  logic [2:0] pre_level;
  logic [6:0] amux_oh;

  int  checks = 0;
  int  fails  = 0;
  bit  run    = 1'b0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  wpr_ctrl_core i_wpr_ctrl_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .st_vac(st_vac), .st_usb(st_usb), .st_otemp(st_otemp), .st_pdc_ovp(st_pdc_ovp),
    .st_pack_ovp(st_pack_ovp), .st_ilim(st_ilim), .trim_usb_keep(trim_usb_keep),
    .rect_mode(rect_mode), .sw_mode(sw_mode), .pre_en(pre_en), .pre_level(pre_level),
    .therm_drv(therm_drv), .mod_en(mod_en), .ovp_fet(ovp_fet), .amux_oh(amux_oh),
    .ldo_from_usb(ldo_from_usb), .low_power(low_power)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] mreg [8];
  logic [5:0] sq [$];      // {vac, pack_ovp, pdc_ovp, otemp, usb, ilim}, oldest first
  logic       marm;
  logic [7:0] mrd;
  logic [5:0] st_vec;

  assign st_vec = {st_vac, st_pack_ovp, st_pdc_ovp, st_otemp, st_usb, st_ilim};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
      sq = {};
      sq.push_back(6'd0);
      sq.push_back(6'd0);
      marm = 1'b0;
      mrd  = 8'h00;
    end else begin
      logic [5:0] ms;
      ms = sq[0];
      if (bus_rd) begin
        if (bus_addr < 4'd8)       mrd = mreg[bus_addr[2:0]];
        else if (bus_addr == 4'd8) mrd = {3'b000, ms[4:0]};
        else                       mrd = 8'h00;
      end
      marm = marm | ms[5] | mreg[0][0] | mreg[0][1];
      if (bus_wr && bus_addr < 4'd8) mreg[bus_addr[2:0]] = bus_wdata;
      if (ms[5]) mreg[1][6] = 1'b0;
      void'(sq.pop_front());
      sq.push_back(st_vec);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [5:0] s;
    logic       vac, pdc, ot, usb, blk, sw, pre, top, chg;
    integer     e_rect, e_sw, e_th, code;
    logic [6:0] e_amux;
    s   = sq[0];
    vac = s[5]; pdc = s[3]; ot = s[2]; usb = s[1];
    blk = usb && !trim_usb_keep;
    sw  = mreg[0][0]; pre = mreg[0][1]; top = mreg[0][2];
    chg = sw || pre;
    if (ot || !marm || !mreg[0][4]) e_rect = 0;
    else if (!mreg[0][5])           e_rect = 1;
    else                            e_rect = 2;
    if (ot || blk)  e_sw = 0;
    else if (top)   e_sw = 2;
    else if (sw)    e_sw = 1;
    else            e_sw = 0;
    case (mreg[3][1:0])
      2'd1:    e_th = 1;
      2'd2:    e_th = chg ? 1 : 0;
      default: e_th = 0;
    endcase
    code   = mreg[2][2:0];
    e_amux = (code == 0) ? 7'd0 : 7'(1 << (code - 1));
    chk("R4 R5 R7 rect_mode",      rect_mode,    e_rect);
    chk("R6 R7 R8 sw_mode",        sw_mode,      e_sw);
    chk("R13 R7 R8 pre_en",        pre_en,       pre && !ot && !blk);
    chk("R13 pre_level",           pre_level,    mreg[1][2:0]);
    chk("R9 therm_drv",            therm_drv,    e_th);
    chk("R7 mod_en",               mod_en,       mreg[0][3]);
    chk("R11 ovp_fet",             ovp_fet,      pdc || mreg[1][7]);
    chk("R10 amux_oh",             amux_oh,      e_amux);
    chk("R8 ldo_from_usb",         ldo_from_usb, blk);
    chk("R12 low_power",           low_power,    mreg[1][6] && !vac);
    chk("R1 R2 R3 bus_rdata",      bus_rdata,    mrd);
  endtask

  always @(negedge clk) begin
    if (run) begin
      #1;
      compare();
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input logic [3:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus(a, d, 1'b1, 1'b0); idle(1);
  endtask

  task automatic rd(input logic [3:0] a);
    bus(a, 8'h00, 1'b0, 1'b1); idle(1);
  endtask

  task automatic status(input logic [5:0] v, input logic keep);
    @(negedge clk);
    {st_vac, st_pack_ovp, st_pdc_ovp, st_otemp, st_usb, st_ilim} = v;
    trim_usb_keep = keep;
    bus_wr = 1'b0; bus_rd = 1'b0;
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    rst_n = 1'b1;
    bus_addr = 4'h0; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    {st_vac, st_pack_ovp, st_pdc_ovp, st_otemp, st_usb, st_ilim} = 6'd0;
    trim_usb_keep = 1'b0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;                          // reset state compared from here (R1)
    idle(2);
    rst_n = 1'b1;
    idle(2);

    // R5: sync bits set but nothing armed -> diode-only holds
    wr(4'h0, 8'h30);
    idle(4);
    status(6'b100000, 1'b0);             // incoming power arms the rectifier
    status(6'b000000, 1'b0);

    // R1: fill and read back every configuration register
    for (int i = 0; i < 8; i++) wr(4'(i), 8'(8'h5A ^ (i * 37)));
    for (int i = 0; i < 8; i++) rd(4'(i));

    // R3: writes to fault and unmapped addresses, reads of unmapped addresses
    wr(4'h8, 8'hFF);
    wr(4'hA, 8'hFF);
    wr(4'hF, 8'h00);
    for (int i = 0; i < 8; i++) rd(4'(i));
    rd(4'h9); rd(4'hC); rd(4'hF);

    // R2: fault byte under each single status bit and some mixes
    for (int i = 0; i < 6; i++) begin
      status(6'(1 << i), 1'b0);
      rd(4'h8);
    end
    status(6'b011111, 1'b1); rd(4'h8);
    status(6'b000000, 1'b0); rd(4'h8);

    // R4 R6: rectifier and load-switch decode across control values
    for (int i = 0; i < 64; i++) begin
      wr(4'h0, 8'(i));
      idle(1);
    end

    // R9: thermistor codes against charge requests
    for (int c = 0; c < 4; c++) begin
      wr(4'h3, 8'(c));
      wr(4'h0, 8'h00); wr(4'h0, 8'h01); wr(4'h0, 8'h02); wr(4'h0, 8'h03);
    end

    // R10: every mux code
    for (int c = 0; c < 8; c++) wr(4'h2, 8'(c));

    // R7 R8 R13: overrides with everything requested
    wr(4'h0, 8'h3F);
    wr(4'h1, 8'h05);
    status(6'b000100, 1'b0);             // over-temperature
    status(6'b000010, 1'b0);             // USB, blocking
    status(6'b000010, 1'b1);             // USB, keep-trim high
    status(6'b000110, 1'b1);
    status(6'b000000, 1'b0);

    // R11: forced clamp and over-voltage
    wr(4'h1, 8'h80);
    status(6'b001000, 1'b0);
    wr(4'h1, 8'h00);
    status(6'b000000, 1'b0);

    // R12: low-power request then incoming power, with a colliding write
    wr(4'h1, 8'h40);
    idle(3);
    @(negedge clk); st_vac = 1'b1;
    idle(1);
    bus(4'h1, 8'h40, 1'b1, 1'b0);        // write lands in the cycle power is synchronized
    idle(3);
    rd(4'h1);
    status(6'b000000, 1'b0);
    wr(4'h1, 8'h40);
    rd(4'h1);

    // R5 again after a fresh reset, armed by a charge request
    do_reset();
    wr(4'h0, 8'h30);
    idle(3);
    wr(4'h0, 8'h32);
    idle(3);

    // mixed traffic
    void'($urandom(11));
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      if (r[3:0] == 4'd0) begin
        @(negedge clk);
        {st_vac, st_pack_ovp, st_pdc_ovp, st_otemp, st_usb, st_ilim} = 6'($urandom);
        trim_usb_keep = r[4];
      end
      bus(4'($urandom % 12), 8'($urandom), r[5], r[6]);
      if (r[7]) idle(1);
    end
    idle(4);

    run  = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule